// File: doc/BRIEF.md
# Indexed Codec Control Register Block

This block is the control-side register file of an audio codec. It decodes a 64-byte window on a simple 32-bit bus and uses the word address (byte address bits [5:2]) to pick one of sixteen direct 32-bit registers. Behind the direct registers sits a second bank of thirty-two 8-bit registers. Software reaches that bank through two direct registers. The low five bits of word 0 choose a slot, and word 1 reads or writes the chosen slot.

Some slots follow their own rules. Slot 3 takes writes but always reads as zero. Slots 11 and 25 ignore writes. Slot 12 carries a fixed revision code and lets software change only one bit of it. Word 2 ignores writes, and word 4 is a control register whose bit 0 restores every register to its reset value. Every access completes in the cycle it is presented, and read data comes back combinationally. The interrupt line is present but is held inactive.

Top module: `ixreg_block`

## Requirements
- R1: After reset, all direct words read 0. Every indirect slot reads 0 except slot 12, which reads 0x8A, and slot 25, which reads 0xA0.
- R2: A write to any word other than 1, 2 and 4 stores all 32 bits, and a read returns the stored word. Only byte address bits [5:2] select the word, so bits [1:0] are ignored.
- R3: Word 0 stores and returns all 32 bits, and its bits [4:0] select the indirect slot. Reads of word 1 return the selected slot in bits [7:0] with zeros above. Writes to word 1 store wdata[7:0] into the selected slot.
- R4: Reading word 1 while the selected slot is 3 returns 0, even after a write to slot 3.
- R5: Writes through word 1 to slots 11 and 25 leave their contents unchanged.
- R6: A write through word 1 to slot 12 stores (wdata[7:0] AND 0x40) OR 0x8A.
- R7: Writes to word 2 are ignored, and word 2 always reads 0.
- R8: A write to word 4 with wdata[0]=1 returns every other direct word and every indirect slot to its R1 value on that same clock edge. Word 4 then reads wdata AND 0x7F.
- R9: A write to word 4 with wdata[0]=0 stores wdata AND 0x7F into word 4 and changes no other register.
- R10: An access to word 1 uses the index that word 0 held before that access. A new index written to word 0 applies from the next access on.
- R11: irq is 0 at all times. A read returns its data in the same cycle as the request, and no access ever waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Access request valid this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq | output | 1 | Interrupt, held low |

## Verification
The assertions assume that bus_en, bus_we, bus_addr and bus_wdata are stable and known around each rising edge while reset is released. They also assume that a write to word 4 with bit 0 set is one ordinary single-cycle access. The stimulus changes inputs only on falling edges and mixes random word addresses, including random byte-offset bits, with random data. It sets bit 0 of control writes only rarely, so the register contents have time to build up between soft resets.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;

  // direct word roles (behaviour depends on these positions)
  localparam int unsigned SEL_WORD    = 0;
  localparam int unsigned PORT_WORD   = 1;
  localparam int unsigned LOCKED_WORD = 2;
  localparam int unsigned CTRL_WORD   = 4;
  localparam int unsigned CTRL_KEEP_BITS = 7;

  // indirect slot roles
  localparam int unsigned HIDDEN_SLOT = 3;
  localparam int unsigned FROZEN_SLOT = 11;
  localparam int unsigned REV_SLOT    = 12;
  localparam int unsigned ID_SLOT     = 25;
  localparam int unsigned REV_FREE_BIT = 6;

  localparam logic [7:0] REV_CODE = 8'h8A;
  localparam logic [7:0] ID_CODE  = 8'hA0;

  typedef enum logic [1:0] {
    DK_PLAIN,
    DK_PORT,
    DK_LOCKED,
    DK_CTRL
  } dir_kind_e;

  typedef enum logic [1:0] {
    SK_PLAIN,
    SK_FROZEN,
    SK_REV
  } slot_kind_e;

  function automatic dir_kind_e dir_kind(int unsigned w);
    if (w == PORT_WORD)   return DK_PORT;
    if (w == LOCKED_WORD) return DK_LOCKED;
    if (w == CTRL_WORD)   return DK_CTRL;
    return DK_PLAIN;
  endfunction

  function automatic slot_kind_e slot_kind(int unsigned s);
    if (s == FROZEN_SLOT || s == ID_SLOT) return SK_FROZEN;
    if (s == REV_SLOT)                    return SK_REV;
    return SK_PLAIN;
  endfunction

  function automatic logic [7:0] slot_init(int unsigned s);
    if (s == REV_SLOT) return REV_CODE;
    if (s == ID_SLOT)  return ID_CODE;
    return 8'h00;
  endfunction

endpackage

// File: rtl/ixreg_reset_sync.sv
module ixreg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ixreg_direct.sv
module ixreg_direct
  import ixreg_pkg::*;
#(
  parameter int N_DIR  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int WAW   = $clog2(N_DIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WAW-1:0]    word,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_rst,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_KEEP_BITS) - 1);

  logic [N_DIR-1:0][DATA_W-1:0] bank;

  assign soft_rst = wr_en && (word == WAW'(CTRL_WORD)) && wdata[0];

  for (genvar i = 0; i < N_DIR; i++) begin : g_word
    localparam dir_kind_e KIND = dir_kind(i);
    if (KIND == DK_PLAIN || KIND == DK_CTRL) begin : g_store
      logic              hit;
      logic              en;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;

      assign hit = wr_en && (word == WAW'(i));
      assign en  = hit || soft_rst;

      always_comb begin
        d = q;
        if (hit) begin
          if (KIND == DK_CTRL) d = wdata & CTRL_MASK;
          else                 d = wdata;
        end else if (soft_rst) begin
          d = '0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end

      assign bank[i] = q;
    end else begin : g_none
      // port word lives in the indirect bank, locked word is constant
      assign bank[i] = '0;
    end
  end

  assign idx     = bank[SEL_WORD][IDX_W-1:0];
  assign rd_word = bank[word];

  // R8: soft reset clears the index and keeps the masked control value
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank[SEL_WORD] == '0) && (bank[CTRL_WORD] == ($past(wdata) & CTRL_MASK)));

  // R9: a control write without bit 0 stores masked value
  a_r9_ctrl_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WAW'(CTRL_WORD) && !wdata[0]) |=> bank[CTRL_WORD] == ($past(wdata) & CTRL_MASK));

  // R10: a new index is visible on the cycle after the write
  a_r10_index_update: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WAW'(SEL_WORD)) |=> idx == $past(wdata[IDX_W-1:0]));

  // R2: plain words store the full value
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word != WAW'(CTRL_WORD) && word != WAW'(PORT_WORD) && word != WAW'(LOCKED_WORD))
      |=> bank[$past(word)] == $past(wdata));

  // R7: the locked word never holds anything
  a_r7_locked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WAW'(LOCKED_WORD)) |=> bank[LOCKED_WORD] == '0);
endmodule

// File: rtl/ixreg_indirect.sv
module ixreg_indirect
  import ixreg_pkg::*;
#(
  parameter int N_IND = 32,
  parameter int IND_W = 8,
  localparam int IDX_W = $clog2(N_IND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             port_wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [IND_W-1:0] wdata,
  output logic [IND_W-1:0] rd_byte
);
  logic [N_IND-1:0][IND_W-1:0] bank;

  for (genvar s = 0; s < N_IND; s++) begin : g_slot
    localparam slot_kind_e KIND = slot_kind(s);
    localparam logic [IND_W-1:0] INIT = IND_W'(slot_init(s));
    if (KIND == SK_PLAIN) begin : g_plain
      logic             hit;
      logic             en;
      logic [IND_W-1:0] q;
      logic [IND_W-1:0] d;

      assign hit = port_wr && (idx == IDX_W'(s));
      assign en  = hit || soft_rst;

      always_comb begin
        d = q;
        if (soft_rst) d = INIT;
        else if (hit) d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= INIT;
        else if (en) q <= d;
      end

      assign bank[s] = q;
    end else if (KIND == SK_REV) begin : g_rev
      // only one bit of the revision slot is writable
      logic hit;
      logic en;
      logic q;
      logic d;

      assign hit = port_wr && (idx == IDX_W'(s));
      assign en  = hit || soft_rst;

      always_comb begin
        d = q;
        if (soft_rst) d = INIT[REV_FREE_BIT];
        else if (hit) d = wdata[REV_FREE_BIT];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= INIT[REV_FREE_BIT];
        else if (en) q <= d;
      end

      always_comb begin
        bank[s] = INIT;
        bank[s][REV_FREE_BIT] = q;
      end
    end else begin : g_frozen
      assign bank[s] = INIT;
    end
  end

  assign rd_byte = (idx == IDX_W'(HIDDEN_SLOT)) ? '0 : bank[idx];

  // R6: revision slot keeps its code and takes one bit from the write
  a_r6_rev_update: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && idx == IDX_W'(REV_SLOT) && !soft_rst)
      |=> bank[REV_SLOT] == (($past(wdata) & IND_W'(8'h40)) | IND_W'(REV_CODE)));

  // R8: soft reset restores the slot bank
  a_r8_ind_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank[0] == '0) && (bank[REV_SLOT] == IND_W'(REV_CODE)) && (bank[HIDDEN_SLOT] == '0));

  // R5: the identity slot never moves away from its code
  a_r5_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && idx == IDX_W'(ID_SLOT)) |=> bank[ID_SLOT] == IND_W'(ID_CODE));
endmodule

// File: rtl/ixreg_block.sv
module ixreg_block
  import ixreg_pkg::*;
#(
  parameter int N_DIR  = 16,
  parameter int N_IND  = 32,
  parameter int DATA_W = 32,
  parameter int IND_W  = 8,
  localparam int ADDR_W = $clog2(N_DIR) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int WAW   = $clog2(N_DIR);
  localparam int IDX_W = $clog2(N_IND);

  logic              rst_n_int;
  logic [WAW-1:0]    word;
  logic              wr_en;
  logic              port_wr;
  logic              soft_rst;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic [IND_W-1:0]  rd_byte;
  logic              unused_byte_bits;

  assign word             = bus_addr[ADDR_W-1:2];
  assign unused_byte_bits = ^bus_addr[1:0];
  assign wr_en            = bus_en && bus_we;
  assign port_wr          = wr_en && (word == WAW'(PORT_WORD));

  ixreg_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ixreg_direct #(
    .N_DIR  (N_DIR),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_direct (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .word     (word),
    .wdata    (bus_wdata),
    .soft_rst (soft_rst),
    .idx      (idx),
    .rd_word  (rd_word)
  );

  ixreg_indirect #(
    .N_IND (N_IND),
    .IND_W (IND_W)
  ) u_indirect (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .soft_rst (soft_rst),
    .port_wr  (port_wr),
    .idx      (idx),
    .wdata    (bus_wdata[IND_W-1:0]),
    .rd_byte  (rd_byte)
  );

  always_comb begin
    if (word == WAW'(PORT_WORD)) bus_rdata = DATA_W'(rd_byte);
    else                         bus_rdata = rd_word;
  end

  assign irq = 1'b0;

  // R4: hidden slot reads as zero through the port
  a_r4_hidden_read: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_en && !bus_we && word == WAW'(PORT_WORD) && idx == IDX_W'(HIDDEN_SLOT)) |-> bus_rdata == '0);

  // R3: port reads carry only one byte
  a_r3_port_width: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_en && word == WAW'(PORT_WORD)) |-> bus_rdata[DATA_W-1:IND_W] == '0);
endmodule

// File: tb/test_ixreg_block.sv
`timescale 1ns/1ps
module test_ixreg_block;
  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk;
  int n_bad;
  bit summary_done;

  logic [31:0] dm [16];
  logic [7:0]  im [32];

  ixreg_block i_ixreg_block (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < 16; k++) dm[k] = '0;
    for (int k = 0; k < 32; k++) im[k] = 8'h00;
    im[12] = 8'h8A;
    im[25] = 8'hA0;
  endfunction

  function automatic void model_write(int w, logic [31:0] v);
    int ix;
    ix = int'(dm[0][4:0]);
    case (w)
      1: begin
        if (ix == 12)                 im[ix] = (v[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) im[ix] = v[7:0];
      end
      2: ;
      4: begin
        if (v[0]) model_reset();
        dm[4] = v & 32'h7F;
      end
      default: dm[w] = v;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int w);
    int ix;
    ix = int'(dm[0][4:0]);
    if (w == 1) return (ix == 3) ? 32'h0 : {24'h0, im[ix]};
    if (w == 2) return 32'h0;
    return dm[w];
  endfunction

  function automatic string tag_of(int w);
    int ix;
    ix = int'(dm[0][4:0]);
    if (w == 0) return "R3";
    if (w == 1) begin
      if (ix == 3) return "R4";
      if (ix == 12) return "R6";
      if (ix == 11 || ix == 25) return "R5";
      return "R3";
    end
    if (w == 2) return "R7";
    if (w == 4) return "R9";
    return "R2";
  endfunction

  task automatic bus_write(int w, logic [31:0] v, logic [1:0] lo);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1;
    bus_addr = {w[3:0], lo};
    bus_wdata = v;
    @(posedge clk);
    model_write(w, v);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(int w, logic [1:0] lo, string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0;
    bus_addr = {w[3:0], lo};
    bus_wdata = $urandom;
    #1;
    check(tag, bus_rdata, model_read(w));
    check("R11", {31'h0, irq}, 32'h0);
    @(posedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int seed;
    n_chk = 0; n_bad = 0; summary_done = 1'b0;
    seed = $urandom(32'h1A2B3C);
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values of the direct words and every slot
    for (int w = 0; w < 16; w++) bus_read(w, 2'b00, "R1");
    for (int s = 0; s < 32; s++) begin
      bus_write(0, 32'(s), 2'b00);
      bus_read(1, 2'b00, (s == 3) ? "R4" : "R1");
    end

    // R2: full-width store, byte offset ignored
    bus_write(5, 32'hDEAD_BEEF, 2'b11);
    bus_read(5, 2'b01, "R2");
    bus_write(15, 32'h1234_5678, 2'b10);
    bus_read(15, 2'b00, "R2");

    // R3: index register keeps all bits, selects by low five
    bus_write(0, 32'hFFFF_FFE7, 2'b00);
    bus_read(0, 2'b00, "R3");
    bus_write(1, 32'hFFFF_FF5C, 2'b00);
    bus_read(1, 2'b00, "R3");

    // R7: locked word
    bus_write(2, 32'hFFFF_FFFF, 2'b00);
    bus_read(2, 2'b00, "R7");

    // R6: revision slot
    bus_write(0, 32'd12, 2'b00);
    bus_write(1, 32'hFF, 2'b00);
    bus_read(1, 2'b00, "R6");
    bus_write(1, 32'h00, 2'b00);
    bus_read(1, 2'b00, "R6");

    // R5: frozen slots
    bus_write(0, 32'd11, 2'b00);
    bus_write(1, 32'h77, 2'b00);
    bus_read(1, 2'b00, "R5");
    bus_write(0, 32'd25, 2'b00);
    bus_write(1, 32'h33, 2'b00);
    bus_read(1, 2'b00, "R5");

    // R4: hidden slot written then read
    bus_write(0, 32'd3, 2'b00);
    bus_write(1, 32'h55, 2'b00);
    bus_read(1, 2'b00, "R4");

    // R10: index change applies to the next access
    bus_write(0, 32'd7, 2'b00);
    bus_write(1, 32'h6C, 2'b00);
    bus_write(0, 32'd8, 2'b00);
    bus_read(1, 2'b00, "R10");
    bus_write(0, 32'd7, 2'b00);
    bus_read(1, 2'b00, "R10");

    // R9: control write without reset
    bus_write(4, 32'hFFFF_FFFE, 2'b00);
    bus_read(4, 2'b00, "R9");
    bus_read(5, 2'b00, "R9");

    // R8: control write with reset
    bus_write(4, 32'hFFFF_FF81, 2'b00);
    bus_read(4, 2'b00, "R8");
    bus_read(5, 2'b00, "R8");
    bus_read(15, 2'b00, "R8");
    bus_read(0, 2'b00, "R8");
    bus_read(1, 2'b00, "R8");
    bus_write(0, 32'd12, 2'b00);
    bus_read(1, 2'b00, "R8");
    bus_write(0, 32'd25, 2'b00);
    bus_read(1, 2'b00, "R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int w;
      logic [31:0] v;
      w = int'($urandom_range(0, 15));
      v = $urandom;
      if (w == 4 && ($urandom_range(0, 15) != 0)) v[0] = 1'b0;
      if (w == 0 && ($urandom_range(0, 3) == 0)) v[4:0] = 5'($urandom_range(0, 3) * 4 + 3 + (($urandom_range(0, 1) == 1) ? 8 : 0));
      if ($urandom_range(0, 1) == 1) bus_write(w, v, 2'($urandom_range(0, 3)));
      else                           bus_read(w, 2'($urandom_range(0, 3)), tag_of(w));
    end

    summary();
  end
endmodule